// File: doc/BRIEF.md
# Sense-Resistor Short Detector

This block watches each switching pulse of a peak-current-mode flyback controller and decides whether the current-sense resistor has been shorted. A healthy sense path shows a rising voltage part way through every on-time. A shorted one stays near zero. At a fixed point after each gate turn-on, the block takes one digitized sense value. It compares that value with a limit derived from the measured line voltage. It counts how many pulses in a row came in under that limit. When the count reaches the trip count, it raises a shutdown request. The request belongs to the auto-restart class of faults and stays up until the fault logic clears it.

The same turn-on timer also drives a leading-edge blanking window. The window masks the cycle current-limit comparator while the turn-on spike rings out. All timing is counted in ticks of an enable input, so the time base is set by the tick rate and not by the clock. With the default counts and a 50 ns tick, blanking lasts 250 ns and the sample falls 4.55 µs into the pulse. The limit is a straight line between two line-voltage codes, clamped at both ends. With the default codes, line code 122 gives sense code 50 and line code 366 gives sense code 100. These correspond to 1 V and 1 mV per step.

Top module: `sense_short_detect`

## Requirements
- R1: After reset, `blank_o` and `auto_restart_req_o` are low and the consecutive-low count is zero.
- R2: `blank_o` is high only while `gate_on_i` is high. It is high in the first cycle the gate is high (the turn-on cycle). It stays high until BLANK_TICKS ticks have been counted in the cycles after the turn-on cycle.
- R3: Each pulse takes exactly one sample. The sample is taken in the cycle where the SAMPLE_TICKS-th tick after the turn-on cycle arrives while the gate is still high.
- R4: A pulse that ends before its sample point takes no sample and leaves the count unchanged.
- R5: The limit is THR_LO + floor((line − LINE_LO)·(THR_HI − THR_LO)/(LINE_HI − LINE_LO)). A sample counts as low only if `sense_i` is strictly below the limit.
- R6: For line codes at or below LINE_LO the limit is THR_LO. For line codes at or above LINE_HI it is THR_HI.
- R7: A sample at or above the limit resets the count to zero.
- R8: `auto_restart_req_o` rises at the clock edge that takes the TRIP_COUNT-th consecutive low sample.
- R9: Once raised, the request stays high until `clear_i`, whatever later samples show.
- R10: `clear_i` drops the request and zeroes the count at the next edge. A sample taken in the same cycle as `clear_i` is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| gate_on_i | input | 1 | Gate command, high while the switch is on |
| tick_i | input | 1 | Time-base enable; timing is counted in these ticks |
| sense_i | input | SENSE_W | Digitized current-sense value |
| line_i | input | LINE_W | Digitized line DC voltage |
| clear_i | input | 1 | Clears the request and the count |
| blank_o | output | 1 | Leading-edge blanking window for the current-limit comparator |
| auto_restart_req_o | output | 1 | Held shutdown request (auto-restart class) |

## Verification
The bench builds the block with BLANK_TICKS=3, SAMPLE_TICKS=6 and TRIP_COUNT=4, and keeps the default line and limit codes. The shortened counts make the full trip sequence cheap to run many times. This allows the count to be rebuilt after a high sample, a pulse cut short before its sample point, and a clear that coincides with a sample. The default codes let the bench check the floor of the interpolation at an interior line value. They also let it check both clamps and the exact boundary where the sense value equals the limit.

// File: rtl/sense_short_detect.sv
module sense_short_detect #(
  parameter int SENSE_W      = 10,
  parameter int LINE_W       = 10,
  parameter int BLANK_TICKS  = 5,
  parameter int SAMPLE_TICKS = 91,
  parameter int TRIP_COUNT   = 11,
  parameter int LINE_LO      = 122,
  parameter int LINE_HI      = 366,
  parameter int THR_LO       = 50,
  parameter int THR_HI       = 100
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               gate_on_i,
  input  logic               tick_i,
  input  logic [SENSE_W-1:0] sense_i,
  input  logic [LINE_W-1:0]  line_i,
  input  logic               clear_i,
  output logic               blank_o,
  output logic               auto_restart_req_o
);

  localparam int MAXT  = (SAMPLE_TICKS > BLANK_TICKS) ? SAMPLE_TICKS : BLANK_TICKS;
  localparam int EW    = $clog2(MAXT + 1);
  localparam int CW    = $clog2(TRIP_COUNT + 1);
  localparam int LSPAN = LINE_HI - LINE_LO;
  localparam int TRISE = THR_HI - THR_LO;
  localparam int PW    = LINE_W + $clog2(TRISE + 1) + 1;

  logic               gate_q;
  logic [EW-1:0]      elapsed;
  logic [CW-1:0]      run;
  logic               req;
  logic [LINE_W-1:0]  over;
  logic [PW-1:0]      prod;
  logic [PW-1:0]      quot;
  logic [SENSE_W-1:0] thr;

  wire rise = gate_on_i & ~gate_q;
  wire fire = gate_on_i & ~rise & tick_i & (elapsed == EW'(SAMPLE_TICKS - 1));
  wire low  = sense_i < thr;

  assign over = line_i - LINE_W'(LINE_LO);
  assign prod = PW'(over) * PW'(TRISE);
  assign quot = prod / PW'(LSPAN);

  always_comb begin
    if (line_i <= LINE_W'(LINE_LO))      thr = SENSE_W'(THR_LO);
    else if (line_i >= LINE_W'(LINE_HI)) thr = SENSE_W'(THR_HI);
    else                                 thr = SENSE_W'(quot) + SENSE_W'(THR_LO);
  end

  assign blank_o            = gate_on_i & (rise | (elapsed < EW'(BLANK_TICKS)));
  assign auto_restart_req_o = req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q  <= 1'b0;
      elapsed <= '0;
      run     <= '0;
      req     <= 1'b0;
    end else begin
      gate_q <= gate_on_i;
      if (rise)
        elapsed <= '0;
      else if (gate_on_i && tick_i && elapsed != EW'(SAMPLE_TICKS))
        elapsed <= elapsed + EW'(1);

      if (clear_i) begin
        run <= '0;
        req <= 1'b0;
      end else if (fire && !req) begin
        if (low) begin
          run <= run + CW'(1);
          if (run == CW'(TRIP_COUNT - 1)) req <= 1'b1;
        end else begin
          run <= '0;
        end
      end
    end
  end

endmodule

// File: rtl/sense_short_detect_chk.sv
module sense_short_detect_chk (
  input logic clk,
  input logic rst_n,
  input logic gate_on_i,
  input logic tick_i,
  input logic clear_i,
  input logic blank_o,
  input logic req_o
);

  a_r2_blank_needs_gate: assert property (@(posedge clk) disable iff (!rst_n)
    blank_o |-> gate_on_i);

  a_r2_blank_at_turn_on: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_on_i) |-> blank_o);

  a_r9_req_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !clear_i) |=> req_o);

  a_r10_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> !req_o);

  a_r3_req_rises_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_o) |-> ($past(gate_on_i) && $past(tick_i)));

endmodule

bind sense_short_detect sense_short_detect_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .gate_on_i (gate_on_i),
  .tick_i    (tick_i),
  .clear_i   (clear_i),
  .blank_o   (blank_o),
  .req_o     (auto_restart_req_o)
);

// File: tb/test_sense_short_detect.sv
module test_sense_short_detect;
  localparam int PERIOD = 10;
  localparam int SW = 10, LW = 10;
  localparam int BLANK = 3, SAMPLE = 6, TRIP = 4;
  localparam int LLO = 122, LHI = 366, TLO = 50, THI = 100;
  localparam int LONG = 2 * SAMPLE + 2;
  localparam int SHORT = 2 * SAMPLE - 1;

  logic clk = 0, rst_n = 0, gate_on = 0, tick = 0, clear = 0;
  logic [SW-1:0] sense = '0;
  logic [LW-1:0] line = LW'(244);
  logic blank, req;
  int checks = 0, errors = 0;
  int m_cnt = 0;
  bit m_req = 0;

  always #(PERIOD/2) clk = ~clk;

  sense_short_detect #(.SENSE_W(SW), .LINE_W(LW), .BLANK_TICKS(BLANK),
    .SAMPLE_TICKS(SAMPLE), .TRIP_COUNT(TRIP), .LINE_LO(LLO), .LINE_HI(LHI),
    .THR_LO(TLO), .THR_HI(THI)) i_sense_short_detect (
    .clk(clk), .rst_n(rst_n), .gate_on_i(gate_on), .tick_i(tick),
    .sense_i(sense), .line_i(line), .clear_i(clear),
    .blank_o(blank), .auto_restart_req_o(req));

  function automatic int exp_thr(input int l);
    if (l <= LLO) return TLO;
    if (l >= LHI) return THI;
    return TLO + ((l - LLO) * (THI - TLO)) / (LHI - LLO);
  endfunction

  task automatic check(input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic pulse(input int sv, input int len, input bit clr_at_sample, input string tag);
    int ticks = 0;
    bit sampled = 0, cleared = 0, tk, will;
    for (int c = 0; c < len; c++) begin
      tk   = (c % 2) == 1;
      will = (c >= 1) && tk && (ticks == SAMPLE - 1);
      @(negedge clk);
      gate_on = 1; tick = tk; sense = SW'(sv); clear = clr_at_sample && will;
      #(PERIOD/4);
      check(int'(blank), int'((c == 0) || (ticks < BLANK)), "R2 blanking window");
      if (c >= 1 && tk && ticks < SAMPLE) ticks++;
      if (will) sampled = 1;
      if (clear) cleared = 1;
    end
    @(negedge clk);
    gate_on = 0; tick = 0; clear = 0;
    if (cleared) begin
      m_cnt = 0; m_req = 0;
    end else if (sampled && !m_req) begin
      if (sv < exp_thr(int'(line))) begin
        m_cnt++;
        if (m_cnt == TRIP) m_req = 1;
      end else m_cnt = 0;
    end
    #(PERIOD/4);
    check(int'(req), int'(m_req), tag);
    check(int'(blank), 0, "R2 blank low with gate off");
    @(negedge clk);
  endtask

  task automatic do_clear();
    @(negedge clk); clear = 1;
    @(negedge clk); clear = 0;
    m_cnt = 0; m_req = 0;
    #(PERIOD/4);
    check(int'(req), 0, "R10 clear drops request");
  endtask

  task automatic t_reset();
    #(PERIOD/4);
    check(int'(req), 0, "R1 request low in reset");
    check(int'(blank), 0, "R1 blank low in reset");
    repeat (2) @(negedge clk);
    rst_n = 1;
    #(PERIOD/4);
    check(int'(req), 0, "R1 request low after reset");
  endtask

  task automatic t_trip();
    line = LW'(244);
    for (int i = 0; i < TRIP; i++) pulse(10, LONG, 0, "R8 trip after consecutive lows");
    check(int'(req), 1, "R8 request raised");
    do_clear();
  endtask

  task automatic t_high_resets();
    for (int i = 0; i < TRIP - 1; i++) pulse(10, LONG, 0, "R7 lows before high");
    pulse(90, LONG, 0, "R7 high sample");
    for (int i = 0; i < TRIP - 1; i++) pulse(10, LONG, 0, "R7 count restarted");
    check(int'(req), 0, "R7 no trip after reset by high");
    pulse(10, LONG, 0, "R7 trip on restarted count");
    check(int'(req), 1, "R7 request after restarted count");
    do_clear();
  endtask

  task automatic t_short_pulse();
    for (int i = 0; i < TRIP - 1; i++) pulse(10, LONG, 0, "R4 lows before short");
    pulse(10, SHORT, 0, "R4 short pulse");
    pulse(90, SHORT, 0, "R4 short high pulse");
    check(int'(req), 0, "R4 short pulses take no sample");
    pulse(10, LONG, 0, "R3 sample completes count");
    check(int'(req), 1, "R3 R4 count kept across short pulses");
    do_clear();
  endtask

  task automatic t_threshold(input int l, input string tag);
    int t;
    line = LW'(l);
    t = exp_thr(l);
    for (int i = 0; i < TRIP; i++) pulse(t, LONG, 0, tag);
    check(int'(req), 0, {tag, " equal to limit is not low"});
    for (int i = 0; i < TRIP; i++) pulse(t - 1, LONG, 0, tag);
    check(int'(req), 1, {tag, " one below limit trips"});
    do_clear();
  endtask

  task automatic t_hold_and_race();
    line = LW'(244);
    for (int i = 0; i < TRIP; i++) pulse(10, LONG, 0, "R9 build trip");
    for (int i = 0; i < 2; i++) pulse(500, LONG, 0, "R9 request held");
    check(int'(req), 1, "R9 high samples do not clear");
    do_clear();
    for (int i = 0; i < TRIP - 1; i++) pulse(10, LONG, 0, "R10 lows before race");
    pulse(10, LONG, 1, "R10 clear with sample");
    for (int i = 0; i < TRIP - 1; i++) pulse(10, LONG, 0, "R10 count from zero");
    check(int'(req), 0, "R10 sample with clear discarded");
  endtask

  initial begin
    t_reset();
    t_trip();
    t_high_resets();
    t_short_pulse();
    t_threshold(244, "R5 mid line");
    t_threshold(200, "R5 floor of interpolation");
    t_threshold(122, "R5 low end");
    t_threshold(366, "R5 high end");
    t_threshold(60, "R6 clamp below");
    t_threshold(700, "R6 clamp above");
    t_hold_and_race();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule